// File: doc/BRIEF.md
# Vector Element Bit-Manipulation Unit

This unit applies one per-element bit operation to a 128-bit slice of a vector register group. Four operations read one source element and write a result of the same width: bit reversal, leading-zero count, trailing-zero count and population count. A fifth operation is a widening logical left shift. It reads source elements from the low half of the slice and writes results twice as wide. The shift amount comes from a second vector, from a scalar, or from a 5-bit immediate.

The unit decodes the operation from the instruction's funct6, funct3 and vs1 fields. A per-element mask keeps inactive destination elements at their previous value. Encodings the unit does not implement are flagged as illegal, and for them the previous destination value is returned unchanged. Operands pass through two register stages, with a valid/ready handshake on both the input and the output.

Top module: `vbitmanip_unit`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 1.
- R2: funct6=010010, funct3=010 and vs1 field 01001 select bit reversal: result bit k of each element is source bit SEW-1-k.
- R3: The same funct6/funct3 with vs1 field 01100 selects the leading-zero count. A zero element yields SEW.
- R4: The same funct6/funct3 with vs1 field 01101 selects the trailing-zero count. A zero element yields SEW.
- R5: The same funct6/funct3 with vs1 field 01110 selects the population count, zero-extended to SEW bits.
- R6: funct6=110101 selects the widening shift. funct3 000 takes the amount from element i of src_b_i (SEW wide). funct3 100 takes it from scalar_i. funct3 011 takes the vs1 field, zero-extended. Source element i is bits [i*SEW +: SEW] of src_a_i, and the 2×SEW result goes to vd_o bits [i*2SEW +: 2SEW].
- R7: The widening shift uses only the low log2(2×SEW) bits of its amount, so it shifts by the amount modulo 2×SEW.
- R8: sew_i values 0, 1, 2 and 3 mean SEW = 8, 16, 32 and 64. Element i of a same-width result occupies vd_o bits [i*SEW +: SEW].
- R9: Mask bit i governs result element i. When the bit is 0, that element of vd_o equals the same bits of vd_old_i.
- R10: Any other encoding, and the widening shift at SEW=64, return illegal_o=1 with vd_o equal to vd_old_i. Legal operations return illegal_o=0.
- R11: An input accepted at clock edge k produces out_valid_o after edge k+2, when the output is not stalled.
- R12: While out_valid_o=1 and out_ready_i=0, vd_o and illegal_o hold their values, and in_ready_o is 0 once both stages are full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Unit can accept a request |
| funct6_i | input | 6 | funct6 field |
| funct3_i | input | 3 | funct3 field |
| vs1_field_i | input | 5 | vs1 field: operation select or shift immediate |
| sew_i | input | 2 | Element width code |
| src_a_i | input | DATA_W | Data source vector |
| src_b_i | input | DATA_W/2 | Per-element shift amounts (vector form) |
| scalar_i | input | 64 | Scalar shift amount |
| mask_i | input | DATA_W/8 | Per-element enable |
| vd_old_i | input | DATA_W | Previous destination value |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer accepts result |
| vd_o | output | DATA_W | Result vector |
| illegal_o | output | 1 | Request encoding was not supported |

## Verification
At SEW=8, every possible byte value goes through all four same-width operations. This shows that each count and reversal is right for every bit pattern, including the zero element that must yield SEW. The wider SEWs get all-zero and all-ones vectors, which pin down the count extremes, and random vectors, which catch lane-placement mistakes that differ only between element positions. The widening shift is swept with amounts at and past 2×SEW in each of its three forms, which separates correct modulo handling from truncation to a wrong width. Random masks with random old values, the illegal encodings, and a stalled output with two requests in flight cover merging, rejection and back-pressure.

// File: rtl/vbm_pkg.sv
package vbm_pkg;

    localparam int ELEN = 64;

    localparam logic [5:0] F6_UNARY = 6'b010010;
    localparam logic [2:0] F3_UNARY = 3'b010;
    localparam logic [4:0] SEL_REV  = 5'b01001;
    localparam logic [4:0] SEL_CLZ  = 5'b01100;
    localparam logic [4:0] SEL_CTZ  = 5'b01101;
    localparam logic [4:0] SEL_POP  = 5'b01110;

    localparam logic [5:0] F6_WSLL  = 6'b110101;
    localparam logic [2:0] F3_VV    = 3'b000;
    localparam logic [2:0] F3_VX    = 3'b100;
    localparam logic [2:0] F3_VI    = 3'b011;

    localparam logic [1:0] SEW_CODE_64 = 2'd3;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_REV,
        OP_CLZ,
        OP_CTZ,
        OP_POP,
        OP_WSLL
    } vbm_op_e;

    typedef enum logic [1:0] {
        SRC_VEC,
        SRC_SCALAR,
        SRC_IMM
    } vbm_src_e;

    typedef struct packed {
        vbm_op_e  op;
        vbm_src_e src;
        logic     illegal;
    } vbm_dec_t;

endpackage

// File: rtl/vbm_decode.sv
module vbm_decode
    import vbm_pkg::*;
(
    input  logic [5:0] funct6_i,
    input  logic [2:0] funct3_i,
    input  logic [4:0] vs1_field_i,
    input  logic [1:0] sew_i,
    output vbm_dec_t   dec_o
);

    always_comb begin
        dec_o = '{op: OP_NONE, src: SRC_VEC, illegal: 1'b1};
        if (funct6_i == F6_UNARY && funct3_i == F3_UNARY) begin
            case (vs1_field_i)
                SEL_REV: dec_o = '{op: OP_REV, src: SRC_VEC, illegal: 1'b0};
                SEL_CLZ: dec_o = '{op: OP_CLZ, src: SRC_VEC, illegal: 1'b0};
                SEL_CTZ: dec_o = '{op: OP_CTZ, src: SRC_VEC, illegal: 1'b0};
                SEL_POP: dec_o = '{op: OP_POP, src: SRC_VEC, illegal: 1'b0};
                default: dec_o = '{op: OP_NONE, src: SRC_VEC, illegal: 1'b1};
            endcase
        end else if (funct6_i == F6_WSLL) begin
            case (funct3_i)
                F3_VV:   dec_o = '{op: OP_WSLL, src: SRC_VEC,    illegal: 1'b0};
                F3_VX:   dec_o = '{op: OP_WSLL, src: SRC_SCALAR, illegal: 1'b0};
                F3_VI:   dec_o = '{op: OP_WSLL, src: SRC_IMM,    illegal: 1'b0};
                default: dec_o = '{op: OP_NONE, src: SRC_VEC,    illegal: 1'b1};
            endcase
            // the doubled width would exceed ELEN
            if (sew_i == SEW_CODE_64) begin
                dec_o = '{op: OP_NONE, src: SRC_VEC, illegal: 1'b1};
            end
        end
    end

endmodule

// File: rtl/vbm_unary_elem.sv
module vbm_unary_elem
    import vbm_pkg::*;
#(
    parameter int W = 8
) (
    input  vbm_op_e        op_i,
    input  logic [W-1:0]   src_i,
    output logic [W-1:0]   res_o
);

    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rev;
    logic [CW-1:0] clz;
    logic [CW-1:0] ctz;
    logic [CW-1:0] pop;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            rev[i] = src_i[W-1-i];
        end

        // highest set bit is visited last and wins
        clz = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (src_i[i]) clz = CW'(W - 1 - i);
        end

        // lowest set bit is visited last and wins
        ctz = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (src_i[i]) ctz = CW'(i);
        end

        pop = '0;
        for (int i = 0; i < W; i++) begin
            pop = pop + CW'(src_i[i]);
        end

        case (op_i)
            OP_REV:  res_o = rev;
            OP_CLZ:  res_o = W'(clz);
            OP_CTZ:  res_o = W'(ctz);
            OP_POP:  res_o = W'(pop);
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/vbm_wsll_elem.sv
module vbm_wsll_elem
    import vbm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]    src_i,
    input  logic [ELEN-1:0] amt_i,
    output logic [2*W-1:0]  res_o
);

    localparam logic [ELEN-1:0] AMT_MASK = ELEN'(2 * W - 1);

    logic [ELEN-1:0] amt_m;

    always_comb begin
        amt_m = amt_i & AMT_MASK;
        res_o = {{W{1'b0}}, src_i} << amt_m;
    end

endmodule

// File: rtl/vbm_lanes.sv
module vbm_lanes
    import vbm_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int MASK_W = DATA_W / 8
) (
    input  vbm_op_e              op_i,
    input  vbm_src_e             src_i,
    input  logic [1:0]           sew_i,
    input  logic [DATA_W-1:0]    a_i,
    input  logic [DATA_W/2-1:0]  b_i,
    input  logic [ELEN-1:0]      scalar_i,
    input  logic [4:0]           imm_i,
    input  logic [MASK_W-1:0]    mask_i,
    input  logic [DATA_W-1:0]    old_i,
    output logic [DATA_W-1:0]    res_o
);

    localparam int NSEW = 4;

    logic [DATA_W-1:0] uni_v  [NSEW];
    logic [DATA_W-1:0] wide_v [NSEW];

    for (genvar g = 0; g < NSEW; g++) begin : g_sew
        localparam int W = 8 << g;
        localparam int N = DATA_W / W;

        logic [DATA_W-1:0] uni;

        for (genvar e = 0; e < N; e++) begin : g_el
            logic [W-1:0] r;
            vbm_unary_elem #(.W(W)) i_unary (
                .op_i  (op_i),
                .src_i (a_i[e*W +: W]),
                .res_o (r)
            );
            assign uni[e*W +: W] = mask_i[e] ? r : old_i[e*W +: W];
        end
        assign uni_v[g] = uni;

        if (g < NSEW - 1) begin : g_wide
            localparam int NW = DATA_W / (2 * W);
            logic [DATA_W-1:0] wide;

            for (genvar e = 0; e < NW; e++) begin : g_wel
                logic [ELEN-1:0] amt;
                logic [2*W-1:0]  r;

                always_comb begin
                    case (src_i)
                        SRC_VEC:    amt = ELEN'(b_i[e*W +: W]);
                        SRC_SCALAR: amt = scalar_i;
                        default:    amt = ELEN'(imm_i);
                    endcase
                end

                vbm_wsll_elem #(.W(W)) i_wsll (
                    .src_i (a_i[e*W +: W]),
                    .amt_i (amt),
                    .res_o (r)
                );
                assign wide[e*2*W +: 2*W] = mask_i[e] ? r : old_i[e*2*W +: 2*W];
            end
            assign wide_v[g] = wide;
        end else begin : g_nowide
            assign wide_v[g] = old_i;
        end
    end

    always_comb begin
        if (op_i == OP_WSLL) res_o = wide_v[sew_i];
        else                 res_o = uni_v[sew_i];
    end

endmodule

// File: rtl/vbitmanip_unit.sv
module vbitmanip_unit
    import vbm_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int MASK_W = DATA_W / 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 in_valid_i,
    output logic                 in_ready_o,
    input  logic [5:0]           funct6_i,
    input  logic [2:0]           funct3_i,
    input  logic [4:0]           vs1_field_i,
    input  logic [1:0]           sew_i,
    input  logic [DATA_W-1:0]    src_a_i,
    input  logic [DATA_W/2-1:0]  src_b_i,
    input  logic [ELEN-1:0]      scalar_i,
    input  logic [MASK_W-1:0]    mask_i,
    input  logic [DATA_W-1:0]    vd_old_i,
    output logic                 out_valid_o,
    input  logic                 out_ready_i,
    output logic [DATA_W-1:0]    vd_o,
    output logic                 illegal_o
);

    typedef struct packed {
        logic                 s1_valid;
        vbm_dec_t             s1_dec;
        logic [1:0]           s1_sew;
        logic [DATA_W-1:0]    s1_a;
        logic [DATA_W/2-1:0]  s1_b;
        logic [ELEN-1:0]      s1_scalar;
        logic [4:0]           s1_imm;
        logic [MASK_W-1:0]    s1_mask;
        logic [DATA_W-1:0]    s1_old;
        logic                 s2_valid;
        logic                 s2_illegal;
        logic [DATA_W-1:0]    s2_res;
    } pipe_t;

    pipe_t             st_d, st_q;
    vbm_dec_t          dec;
    logic [DATA_W-1:0] lane_res;
    logic              adv;

    vbm_decode i_decode (
        .funct6_i    (funct6_i),
        .funct3_i    (funct3_i),
        .vs1_field_i (vs1_field_i),
        .sew_i       (sew_i),
        .dec_o       (dec)
    );

    vbm_lanes #(.DATA_W(DATA_W), .MASK_W(MASK_W)) i_lanes (
        .op_i     (st_q.s1_dec.op),
        .src_i    (st_q.s1_dec.src),
        .sew_i    (st_q.s1_sew),
        .a_i      (st_q.s1_a),
        .b_i      (st_q.s1_b),
        .scalar_i (st_q.s1_scalar),
        .imm_i    (st_q.s1_imm),
        .mask_i   (st_q.s1_mask),
        .old_i    (st_q.s1_old),
        .res_o    (lane_res)
    );

    always_comb begin
        st_d = st_q;
        adv  = !st_q.s2_valid || out_ready_i;
        if (adv) begin
            st_d.s2_valid   = st_q.s1_valid;
            st_d.s2_illegal = st_q.s1_dec.illegal;
            st_d.s2_res     = st_q.s1_dec.illegal ? st_q.s1_old : lane_res;
            st_d.s1_valid   = in_valid_i;
            if (in_valid_i) begin
                st_d.s1_dec    = dec;
                st_d.s1_sew    = sew_i;
                st_d.s1_a      = src_a_i;
                st_d.s1_b      = src_b_i;
                st_d.s1_scalar = scalar_i;
                st_d.s1_imm    = vs1_field_i;
                st_d.s1_mask   = mask_i;
                st_d.s1_old    = vd_old_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign in_ready_o  = adv;
    assign out_valid_o = st_q.s2_valid;
    assign vd_o        = st_q.s2_res;
    assign illegal_o   = st_q.s2_valid & st_q.s2_illegal;

endmodule

// File: rtl/vbm_chk.sv
module vbm_chk #(
    parameter int DATA_W = 128
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              in_valid_i,
    input logic              in_ready_o,
    input logic              out_valid_o,
    input logic              out_ready_i,
    input logic [DATA_W-1:0] vd_o,
    input logic              illegal_o
);

    // R1
    reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> !out_valid_o && in_ready_o);

    // R11
    latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(in_valid_i && in_ready_o, 2) && $past(out_ready_i, 1)) |-> out_valid_o);

    // R12
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_ready_i) |=> out_valid_o && $stable(vd_o) && $stable(illegal_o));

    // R12
    stall_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_ready_i) |-> !in_ready_o);

    // R10
    illegal_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> out_valid_o);

endmodule

bind vbitmanip_unit vbm_chk #(.DATA_W(DATA_W)) i_vbm_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .vd_o        (vd_o),
    .illegal_o   (illegal_o)
);

// File: tb/test_vbitmanip_unit.sv
module test_vbitmanip_unit;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic         in_valid_i = 1'b0;
    logic         in_ready_o;
    logic [5:0]   funct6_i = '0;
    logic [2:0]   funct3_i = '0;
    logic [4:0]   vs1_field_i = '0;
    logic [1:0]   sew_i = '0;
    logic [127:0] src_a_i = '0;
    logic [63:0]  src_b_i = '0;
    logic [63:0]  scalar_i = '0;
    logic [15:0]  mask_i = '0;
    logic [127:0] vd_old_i = '0;
    logic         out_valid_o;
    logic         out_ready_i = 1'b1;
    logic [127:0] vd_o;
    logic         illegal_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #4 clk_i = ~clk_i;

    vbitmanip_unit i_vbitmanip_unit (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .in_valid_i  (in_valid_i),
        .in_ready_o  (in_ready_o),
        .funct6_i    (funct6_i),
        .funct3_i    (funct3_i),
        .vs1_field_i (vs1_field_i),
        .sew_i       (sew_i),
        .src_a_i     (src_a_i),
        .src_b_i     (src_b_i),
        .scalar_i    (scalar_i),
        .mask_i      (mask_i),
        .vd_old_i    (vd_old_i),
        .out_valid_o (out_valid_o),
        .out_ready_i (out_ready_i),
        .vd_o        (vd_o),
        .illegal_o   (illegal_o)
    );

    task automatic finish_sim();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    // reference model computed from the requirements
    task automatic model(input logic [5:0] f6, input logic [2:0] f3, input logic [4:0] v1,
                         input logic [1:0] sew, input logic [127:0] a, input logic [63:0] b,
                         input logic [63:0] sc, input logic [15:0] m, input logic [127:0] old,
                         output logic [127:0] res, output logic ill);
        int w;
        logic [63:0] wm;
        bit is_un, is_w;
        w  = 8 << sew;
        wm = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        res = old;
        is_un = (f6 == 6'b010010) && (f3 == 3'b010) &&
                (v1 == 5'b01001 || v1 == 5'b01100 || v1 == 5'b01101 || v1 == 5'b01110);
        is_w  = (f6 == 6'b110101) && (f3 == 3'b000 || f3 == 3'b100 || f3 == 3'b011) && (sew != 2'd3);
        ill = !(is_un || is_w);
        if (is_un) begin
            for (int e = 0; e < 128 / w; e++) begin
                logic [63:0] x, r, t;
                int n;
                x = 64'(a >> (e * w)) & wm;
                r = '0;
                n = 0;
                case (v1)
                    5'b01001: for (int k = 0; k < w; k++) r[k] = x[w-1-k];
                    5'b01100: begin
                        while (n < w && x[w-1-n] == 1'b0) n++;
                        r = 64'(n);
                    end
                    5'b01101: begin
                        while (n < w && x[n] == 1'b0) n++;
                        r = 64'(n);
                    end
                    default: begin
                        t = x;
                        while (t != 0) begin t = t & (t - 1); n++; end
                        r = 64'(n);
                    end
                endcase
                if (m[e]) for (int k = 0; k < w; k++) res[e*w+k] = r[k];
            end
        end
        if (is_w) begin
            for (int e = 0; e < 64 / w; e++) begin
                logic [63:0]  x, s;
                logic [127:0] wide;
                int sh;
                x = 64'(a >> (e * w)) & wm;
                if (f3 == 3'b000)      s = (b >> (e * w)) & wm;
                else if (f3 == 3'b100) s = sc;
                else                   s = 64'(v1);
                sh = int'(s % 64'(2 * w));
                wide = 128'(x) << sh;
                if (m[e]) for (int k = 0; k < 2 * w; k++) res[e*2*w+k] = wide[k];
            end
        end
    endtask

    task automatic run(input string tag, input logic [5:0] f6, input logic [2:0] f3,
                       input logic [4:0] v1, input logic [1:0] sew, input logic [127:0] a,
                       input logic [63:0] b, input logic [63:0] sc, input logic [15:0] m,
                       input logic [127:0] old);
        logic [127:0] exp;
        logic exp_ill;
        model(f6, f3, v1, sew, a, b, sc, m, old, exp, exp_ill);
        @(negedge clk_i);
        funct6_i = f6; funct3_i = f3; vs1_field_i = v1; sew_i = sew;
        src_a_i = a; src_b_i = b; scalar_i = sc; mask_i = m; vd_old_i = old;
        in_valid_i = 1'b1;
        @(negedge clk_i);
        in_valid_i = 1'b0;
        chk("R11 early", 128'(out_valid_o), 128'(0));
        @(negedge clk_i);
        chk("R11 valid", 128'(out_valid_o), 128'(1));
        chk(tag, vd_o, exp);
        chk({"R10 flag ", tag}, 128'(illegal_o), 128'(exp_ill));
    endtask

    localparam logic [4:0] UN_SEL [4] = '{5'b01001, 5'b01100, 5'b01101, 5'b01110};
    localparam logic [2:0] W_F3   [3] = '{3'b000, 3'b100, 3'b011};

    initial begin
        #(8 * 150000);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        string tags [4];
        tags[0] = "R2"; tags[1] = "R3"; tags[2] = "R4"; tags[3] = "R5";
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk("R1 out_valid", 128'(out_valid_o), 128'(0));
        chk("R1 in_ready", 128'(in_ready_o), 128'(1));

        // every byte value through every same-width operation
        for (int op = 0; op < 4; op++) begin
            for (int j = 0; j < 16; j++) begin
                logic [127:0] a;
                for (int k = 0; k < 16; k++) a[k*8 +: 8] = 8'(j * 16 + k);
                run({tags[op], " sew8"}, 6'b010010, 3'b010, UN_SEL[op], 2'd0, a, '0, '0, '1, rnd128());
            end
        end

        // wider SEWs: extremes and random patterns
        for (int op = 0; op < 4; op++) begin
            for (int s = 1; s < 4; s++) begin
                run({tags[op], " R8 zero"}, 6'b010010, 3'b010, UN_SEL[op], 2'(s), '0, '0, '0, '1, rnd128());
                run({tags[op], " R8 ones"}, 6'b010010, 3'b010, UN_SEL[op], 2'(s), '1, '0, '0, '1, rnd128());
                for (int t = 0; t < 12; t++) begin
                    run({tags[op], " R8 rand"}, 6'b010010, 3'b010, UN_SEL[op], 2'(s), rnd128(), '0, '0, '1, rnd128());
                end
            end
        end

        // widening shift, all forms, amounts past 2*SEW
        for (int s = 0; s < 3; s++) begin
            for (int f = 0; f < 3; f++) begin
                for (int t = 0; t < 16; t++) begin
                    logic [63:0] sc;
                    sc = {$urandom(), $urandom()};
                    sc[7:0] = 8'(t * 5);
                    run("R6 R7 wsll", 6'b110101, W_F3[f], 5'(t * 2 + 1), 2'(s), rnd128(),
                        {$urandom(), $urandom()}, sc, '1, rnd128());
                end
            end
        end

        // masked elements keep the old value
        for (int t = 0; t < 24; t++) begin
            int op;
            op = t % 4;
            run({"R9 ", tags[op]}, 6'b010010, 3'b010, UN_SEL[op], 2'(t % 4), rnd128(), '0, '0,
                16'($urandom()), rnd128());
        end
        for (int t = 0; t < 9; t++) begin
            run("R9 R6 wsll", 6'b110101, W_F3[t % 3], 5'(t), 2'(t % 3), rnd128(),
                {$urandom(), $urandom()}, 64'(t * 3), 16'($urandom()), rnd128());
        end

        // unsupported encodings
        run("R10 bad vs1",   6'b010010, 3'b010, 5'b00000, 2'd0, rnd128(), '0, '0, '1, rnd128());
        run("R10 bad f3",    6'b010010, 3'b011, 5'b01001, 2'd1, rnd128(), '0, '0, '1, rnd128());
        run("R10 wsll f3",   6'b110101, 3'b001, 5'b00001, 2'd0, rnd128(), '0, '0, '1, rnd128());
        run("R10 wsll sew64",6'b110101, 3'b000, 5'b00001, 2'd3, rnd128(), '1, '0, '1, rnd128());
        run("R10 bad f6",    6'b000000, 3'b010, 5'b01100, 2'd2, rnd128(), '0, '0, '1, rnd128());

        // back-pressure: two requests in flight, output stalled
        begin
            logic [127:0] a0, a1, o0, o1, e0, e1;
            logic i0, i1;
            a0 = rnd128(); a1 = rnd128(); o0 = rnd128(); o1 = rnd128();
            model(6'b010010, 3'b010, 5'b01110, 2'd1, a0, '0, '0, '1, o0, e0, i0);
            model(6'b010010, 3'b010, 5'b01100, 2'd2, a1, '0, '0, '1, o1, e1, i1);
            @(negedge clk_i);
            out_ready_i = 1'b0;
            funct6_i = 6'b010010; funct3_i = 3'b010; vs1_field_i = 5'b01110; sew_i = 2'd1;
            src_a_i = a0; mask_i = '1; vd_old_i = o0; in_valid_i = 1'b1;
            @(negedge clk_i);
            vs1_field_i = 5'b01100; sew_i = 2'd2; src_a_i = a1; vd_old_i = o1;
            @(negedge clk_i);
            in_valid_i = 1'b0;
            chk("R12 in_ready low", 128'(in_ready_o), 128'(0));
            chk("R12 valid", 128'(out_valid_o), 128'(1));
            repeat (3) @(negedge clk_i);
            chk("R12 held", vd_o, e0);
            out_ready_i = 1'b1;
            chk("R12 first", vd_o, e0);
            @(negedge clk_i);
            chk("R12 second valid", 128'(out_valid_o), 128'(1));
            chk("R12 second", vd_o, e1);
            @(negedge clk_i);
            chk("R12 drained", 128'(out_valid_o), 128'(0));
        end

        finish_sim();
    end

endmodule